// File: doc/BRIEF.md
# Narrow Memory Width Adapter

This block connects a 32-bit bus slave port to one external asynchronous memory bank whose data path is 8 or 16 bits wide. It turns each accepted bus request into timed device strobes (chip enable, output enable, write enable), moves the data between the wide bus and the narrow device, and acknowledges the bus once when the transaction is over.

A build-time switch picks the mode of the bank. With the switch on, the bank looks like a 32-bit device for reads: one bus read becomes two (16-bit device) or four (8-bit device) device reads in a row, and the pieces are packed into one word. Writes are never split, whatever the switch says. Each bus write is exactly one device write of native width. This keeps flash programming sequences intact, where a command cycle must be followed directly by its data cycle. With the switch off, every bus access is one device access, and the narrow data sits on the byte lane that the low address bits select.

Top module: `narrow_mem_bridge`

## Requirements
- R1: While reset is held and after it is released, with no request given, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high and `bus_ack` is low.
- R2: With matching off, a bus read is one device read at unit address `bus_addr >> log2(DEV_W/8)`. Lane k = `bus_addr[1:0] >> log2(DEV_W/8)` gets the device data in `bus_rdata[31-k*DEV_W -: DEV_W]`, and every other bit of `bus_rdata` is zero.
- R3: With matching on, a bus read is 32/DEV_W device reads at consecutive unit addresses, starting from the word-aligned unit address. The first device word is placed in the most significant lane, and so on down.
- R4: A bus write is exactly one device write at unit address `bus_addr >> log2(DEV_W/8)`, in both modes. `mem_wdata` carries `bus_wdata[31-k*DEV_W -: DEV_W]`, with k as in R2.
- R5: Each device access holds `mem_ce_n` low, and `mem_oe_n` (read) or `mem_we_n` (write) low, for exactly STROBE_CYC cycles. After each access all strobes are high for at least one cycle, and consecutive accesses of one transaction start STROBE_CYC+1 cycles apart.
- R6: `bus_ack` is high for exactly one cycle, in the cycle that follows the last strobe cycle of the transaction. That is N*(STROBE_CYC+1) cycles after the accepting edge, for N accesses. `bus_rdata` holds its value in that cycle and in the cycle after it.
- R7: A request seen while a transaction is in progress is ignored. It starts no device access, either then or later.
- R8: Every bit of the device data and of the selected write lane passes through unchanged. No bit is masked or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Request, sampled while the adapter is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW-log2(DEV_W/8) | Device address in device-width units |
| mem_wdata | output | DEV_W | Device write data |
| mem_rdata | input | DEV_W | Device read data |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |

## Verification
Two instances are swept: an 8-bit bank with matching on and a 16-bit bank with matching off. On both, every byte address is read from a device model whose contents are a fixed arithmetic function of the address. This separates wrong lane choice, wrong packing order, wrong start alignment and a missing address step. Writes with walking single-bit and inverted patterns over varied low address bits show that a matched bank still issues one access, and that every lane bit arrives. Requests raised while a transaction runs show that busy-time requests are dropped rather than queued.

// File: rtl/narrow_bridge_pkg.sv
// Shared types for the narrow memory width adapter.
// Assumes a 32-bit bus and a device width of 8 or 16 bits.
package narrow_bridge_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_GAP    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/access_sequencer.sv
// Access sequencer: accepts a bus request while idle and latches it.
// It then runs one or more device accesses of STROBE_CYC strobe cycles,
// each followed by one idle cycle, and acknowledges after the last one.
// Assumes DEV_W is 8 or 16. Matching splits reads only; writes are one access.
module access_sequencer
    import narrow_bridge_pkg::*;
#(
    parameter int DEV_W      = 16,
    parameter bit MATCH_EN   = 1'b1,
    parameter int STROBE_CYC = 2,
    parameter int AW         = 24,
    localparam int NL = BUS_W / DEV_W,
    localparam int SH = $clog2(DEV_W / 8),
    localparam int LW = (NL > 1) ? $clog2(NL) : 1,
    localparam int UW = AW - SH,
    localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] wdata_q,
    output logic [LW-1:0]    lane_q,
    output logic             start,
    output logic             cap_en,
    output logic             ack,
    output logic [UW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n
);
    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [LW-1:0] beat;
    logic [LW-1:0] last_q;
    logic          we_q;
    logic [1:0]    low_in;
    logic [UW-1:0] unit_in;
    logic          split;

    // Decode the incoming request: lane, unit address, split or not.
    always_comb begin
        low_in  = addr[1:0];
        unit_in = addr[AW-1:SH];
        split   = MATCH_EN && !we;
        start   = (state == SQ_IDLE) && req;
        cap_en  = (state == SQ_STROBE) && (cnt == CW'(STROBE_CYC - 1)) && !we_q;
        ack     = (state == SQ_GAP) && (beat == last_q);
    end

    // State, counters and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            beat     <= '0;
            last_q   <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            lane_q   <= '0;
            mem_addr <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (req) begin
                    state    <= SQ_STROBE;
                    cnt      <= '0;
                    beat     <= '0;
                    we_q     <= we;
                    wdata_q  <= wdata;
                    lane_q   <= LW'(low_in >> SH);
                    last_q   <= split ? LW'(NL - 1) : '0;
                    mem_addr <= split ? (unit_in & ~UW'(NL - 1)) : unit_in;
                end
                SQ_STROBE: begin
                    if (cnt == CW'(STROBE_CYC - 1)) begin
                        state <= SQ_GAP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (beat == last_q) begin
                        state <= SQ_IDLE;
                    end else begin
                        state    <= SQ_STROBE;
                        beat     <= beat + 1'b1;
                        mem_addr <= mem_addr + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Strobes follow the state: low only during the strobe phase.
    always_comb begin
        mem_ce_n = (state != SQ_STROBE);
        mem_oe_n = !((state == SQ_STROBE) && !we_q);
        mem_we_n = !((state == SQ_STROBE) && we_q);
    end

    // Assertion-only counter of consecutive chip-enable-low cycles.
    logic [CW:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= '0;
        else if (mem_ce_n) low_run <= '0;
        else               low_run <= low_run + 1'b1;
    end

    a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r4_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GAP && we_q) |-> ack);
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GAP && !ack) |=> mem_addr == $past(mem_addr) + 1'b1);
    a_r5_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> low_run == (CW+1)'(STROBE_CYC));
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_STROBE) |=> $stable(we_q) && $stable(lane_q));
endmodule

// File: rtl/lane_steer.sv
// Lane steering: selects the narrow write lane out of the latched bus word
// and places narrow read data in the same lane, zero elsewhere.
// Lane 0 is the most significant lane (big-endian order).
module lane_steer
    import narrow_bridge_pkg::*;
#(
    parameter int DEV_W = 16,
    localparam int NL = BUS_W / DEV_W,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [LW-1:0]    lane,
    input  logic [BUS_W-1:0] wdata_q,
    input  logic [DEV_W-1:0] mem_rdata,
    output logic [DEV_W-1:0] mem_wdata,
    output logic [BUS_W-1:0] rd_placed
);
    // Pick and place one lane, all of its bits passed through.
    always_comb begin
        mem_wdata = '0;
        rd_placed = '0;
        for (int k = 0; k < NL; k++) begin
            if (lane == LW'(k)) begin
                mem_wdata = wdata_q[BUS_W-1-k*DEV_W -: DEV_W];
                rd_placed[BUS_W-1-k*DEV_W -: DEV_W] = mem_rdata;
            end
        end
    end
endmodule

// File: rtl/read_assembler.sv
// Read assembler: builds the bus read word. When matched, each captured
// narrow word shifts in from the bottom, so the first lands in the top lane.
// When not matched, the lane-placed word is loaded. Cleared on each new request.
module read_assembler
    import narrow_bridge_pkg::*;
#(
    parameter int DEV_W    = 16,
    parameter bit MATCH_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cap_en,
    input  logic             ack,
    input  logic [DEV_W-1:0] mem_rdata,
    input  logic [BUS_W-1:0] rd_placed,
    output logic [BUS_W-1:0] rdata
);
    generate
        if (MATCH_EN) begin : g_pack
            // Shift narrow reads in, first one ending in the top lane.
            always_ff @(posedge clk) begin
                if (!rst_n)      rdata <= '0;
                else if (start)  rdata <= '0;
                else if (cap_en) rdata <= {rdata[BUS_W-DEV_W-1:0], mem_rdata};
            end
        end else begin : g_place
            // Load the single narrow read into its addressed lane.
            always_ff @(posedge clk) begin
                if (!rst_n)      rdata <= '0;
                else if (start)  rdata <= '0;
                else if (cap_en) rdata <= rd_placed;
            end
        end
    endgenerate

    a_r6_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> rdata == $past(rdata));
endmodule

// File: rtl/narrow_mem_bridge.sv
// Narrow memory width adapter top: 32-bit bus slave to an 8- or 16-bit
// asynchronous memory bank. MATCH_EN turns on read splitting for the bank.
// Writes always stay single accesses. One bank, no address decoding.
module narrow_mem_bridge
    import narrow_bridge_pkg::*;
#(
    parameter int DEV_W      = 16,
    parameter bit MATCH_EN   = 1'b1,
    parameter int STROBE_CYC = 2,
    parameter int AW         = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_req,
    input  logic                          bus_we,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          bus_ack,
    output logic [AW-$clog2(DEV_W/8)-1:0] mem_addr,
    output logic [DEV_W-1:0]              mem_wdata,
    input  logic [DEV_W-1:0]              mem_rdata,
    output logic                          mem_ce_n,
    output logic                          mem_oe_n,
    output logic                          mem_we_n
);
    localparam int NL = BUS_W / DEV_W;
    localparam int LW = (NL > 1) ? $clog2(NL) : 1;

    logic [BUS_W-1:0] wdata_q;
    logic [BUS_W-1:0] rd_placed;
    logic [LW-1:0]    lane_q;
    logic             start;
    logic             cap_en;

    access_sequencer #(
        .DEV_W(DEV_W), .MATCH_EN(MATCH_EN), .STROBE_CYC(STROBE_CYC), .AW(AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .wdata_q(wdata_q),
        .lane_q(lane_q), .start(start), .cap_en(cap_en), .ack(bus_ack),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    lane_steer #(.DEV_W(DEV_W)) u_steer (
        .lane(lane_q), .wdata_q(wdata_q), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .rd_placed(rd_placed)
    );

    read_assembler #(.DEV_W(DEV_W), .MATCH_EN(MATCH_EN)) u_asm (
        .clk(clk), .rst_n(rst_n), .start(start), .cap_en(cap_en),
        .ack(bus_ack), .mem_rdata(mem_rdata), .rd_placed(rd_placed),
        .rdata(bus_rdata)
    );
endmodule

// File: tb/test_narrow_mem_bridge.sv
`timescale 1ns/1ps
// Bench: instance 0 is an 8-bit bank with matching on, instance 1 a 16-bit
// bank with matching off. The device models return an arithmetic function of
// the address. A negedge monitor logs every device access.
module test_narrow_mem_bridge;
    localparam int S  = 2;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_v [2];
    logic        we_v  [2];
    logic [7:0]  addr_v[2];
    logic [31:0] wd_v  [2];
    logic [31:0] rd_v  [2];
    logic        ack_v [2];
    logic        ce_v  [2];
    logic        oe_v  [2];
    logic        wen_v [2];
    logic [31:0] ma_v  [2];
    logic [31:0] mw_v  [2];

    logic [7:0]  ma_a, mw_a, mr_a;
    logic [6:0]  ma_b;
    logic [15:0] mw_b, mr_b;

    function automatic logic [7:0] f8(int u);
        return 8'(u * 37 + 91);
    endfunction
    function automatic logic [15:0] f16(int u);
        return 16'(u * 3869) ^ 16'hC35A;
    endfunction

    assign mr_a = f8(int'(ma_a));
    assign mr_b = f16(int'(ma_b));
    assign ma_v[0] = 32'(ma_a);
    assign ma_v[1] = 32'(ma_b);
    assign mw_v[0] = 32'(mw_a);
    assign mw_v[1] = 32'(mw_b);

    narrow_mem_bridge #(.DEV_W(8), .MATCH_EN(1'b1), .STROBE_CYC(S), .AW(AW)) i_narrow_mem_bridge (
        .clk(clk), .rst_n(rst_n), .bus_req(req_v[0]), .bus_we(we_v[0]),
        .bus_addr(addr_v[0]), .bus_wdata(wd_v[0]), .bus_rdata(rd_v[0]),
        .bus_ack(ack_v[0]), .mem_addr(ma_a), .mem_wdata(mw_a), .mem_rdata(mr_a),
        .mem_ce_n(ce_v[0]), .mem_oe_n(oe_v[0]), .mem_we_n(wen_v[0])
    );

    narrow_mem_bridge #(.DEV_W(16), .MATCH_EN(1'b0), .STROBE_CYC(S), .AW(AW)) i_narrow_mem_bridge_nm (
        .clk(clk), .rst_n(rst_n), .bus_req(req_v[1]), .bus_we(we_v[1]),
        .bus_addr(addr_v[1]), .bus_wdata(wd_v[1]), .bus_rdata(rd_v[1]),
        .bus_ack(ack_v[1]), .mem_addr(ma_b), .mem_wdata(mw_b), .mem_rdata(mr_b),
        .mem_ce_n(ce_v[1]), .mem_oe_n(oe_v[1]), .mem_we_n(wen_v[1])
    );

    int total = 0;
    int bad = 0;
    int tick = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Access log, filled by the monitor.
    int   n_acc  [2];
    int   a_addr [2][8];
    int   a_wr   [2][8];
    int   a_wd   [2][8];
    int   a_run  [2][8];
    int   a_bad  [2][8];
    int   a_start[2][8];
    int   cur_run[2];
    logic prev_ce[2];

    // Monitor: logs each device access and its strobe length.
    always @(negedge clk) begin
        tick++;
        for (int i = 0; i < 2; i++) begin
            if (ce_v[i] === 1'b0) begin
                if (prev_ce[i] === 1'b1) begin
                    if (n_acc[i] < 8) begin
                        a_addr[i][n_acc[i]]  = int'(ma_v[i]);
                        a_wr[i][n_acc[i]]    = (wen_v[i] === 1'b0) ? 1 : 0;
                        a_wd[i][n_acc[i]]    = int'(mw_v[i]);
                        a_start[i][n_acc[i]] = tick;
                        a_bad[i][n_acc[i]]   = 0;
                    end
                    n_acc[i]++;
                    cur_run[i] = 1;
                end else begin
                    cur_run[i]++;
                end
                if (n_acc[i] >= 1 && n_acc[i] <= 8) begin
                    if (a_wr[i][n_acc[i]-1] == 1 && !(wen_v[i] === 1'b0 && oe_v[i] === 1'b1))
                        a_bad[i][n_acc[i]-1] = 1;
                    if (a_wr[i][n_acc[i]-1] == 0 && !(oe_v[i] === 1'b0 && wen_v[i] === 1'b1))
                        a_bad[i][n_acc[i]-1] = 1;
                end
            end else if (prev_ce[i] === 1'b0 && n_acc[i] >= 1 && n_acc[i] <= 8) begin
                a_run[i][n_acc[i]-1] = cur_run[i];
            end
            prev_ce[i] = ce_v[i];
        end
    end

    // One bus transaction with all checks; poke raises req while busy (R7).
    task automatic xact(input int i, input bit wr, input int a, input logic [31:0] wd, input bit poke);
        int n;
        int lat;
        int exp_addr[4];
        logic [31:0] exp_rd;
        logic [31:0] got;
        int k;
        k = (i == 0) ? (a % 4) : ((a >> 1) & 1);
        if (i == 0 && !wr) begin
            n = 4;
            exp_rd = '0;
            for (int j = 0; j < 4; j++) begin
                exp_addr[j] = (a & ~3) + j;
                exp_rd = {exp_rd[23:0], f8(exp_addr[j])};
            end
        end else begin
            n = 1;
            exp_addr[0] = (i == 0) ? a : (a >> 1);
            exp_rd = (i == 0) ? 32'h0 : (32'(f16(a >> 1)) << (16 * (1 - k)));
        end
        n_acc[i] = 0;
        @(negedge clk);
        req_v[i] = 1'b1; we_v[i] = wr; addr_v[i] = a[7:0]; wd_v[i] = wd;
        @(negedge clk);
        req_v[i] = 1'b0;
        lat = 1;
        while (ack_v[i] !== 1'b1 && lat < 200) begin
            if (poke && lat == 1) begin
                req_v[i] = 1'b1; we_v[i] = ~wr; addr_v[i] = a[7:0] ^ 8'h5A;
            end else begin
                req_v[i] = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req_v[i] = 1'b0;
        check("R6 ack latency", 32'(lat), 32'(n * (S + 1)));
        got = rd_v[i];
        if (!wr) check(i == 0 ? "R3 packed read" : "R2 lane read", got, exp_rd);
        @(negedge clk);
        check("R6 ack one cycle", 32'(ack_v[i]), 32'h0);
        check("R6 rdata held", rd_v[i], got);
        repeat (6) @(negedge clk);
        check(poke ? "R7 busy request ignored" : (wr ? "R4 single write" : "R3 access count"),
              32'(n_acc[i]), 32'(n));
        for (int j = 0; j < n && j < n_acc[i]; j++) begin
            check(wr ? "R4 write address" : (i == 0 ? "R3 read address" : "R2 read address"),
                  32'(a_addr[i][j]), 32'(exp_addr[j]));
            check("R5 strobe length", 32'(a_run[i][j]), 32'(S));
            check("R5 strobe kind", 32'(a_wr[i][j] * 2 + a_bad[i][j]), wr ? 32'd2 : 32'd0);
            if (j > 0) check("R5 access spacing", 32'(a_start[i][j] - a_start[i][j-1]), 32'(S + 1));
        end
        if (wr && n_acc[i] >= 1) begin
            if (i == 0) check("R4 R8 write lane 8", 32'(a_wd[i][0]), (wd >> (8 * (3 - k))) & 32'hFF);
            else        check("R4 R8 write lane 16", 32'(a_wd[i][0]), (wd >> (16 * (1 - k))) & 32'hFFFF);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 2; i++) begin
            req_v[i] = 1'b0; we_v[i] = 1'b0; addr_v[i] = '0; wd_v[i] = '0;
            n_acc[i] = 0; cur_run[i] = 0; prev_ce[i] = 1'b1;
        end
        repeat (4) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check("R1 reset strobes", {29'h0, ce_v[i], oe_v[i], wen_v[i]}, 32'h7);
            check("R1 reset ack", 32'(ack_v[i]), 32'h0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check("R1 idle strobes", {29'h0, ce_v[i], oe_v[i], wen_v[i]}, 32'h7);
            check("R1 idle ack", 32'(ack_v[i]), 32'h0);
        end
        // R2 R3 R8: every byte address read on both banks.
        for (int a = 0; a < 256; a++) begin
            xact(0, 1'b0, a, 32'h0, 1'b0);
            xact(1, 1'b0, a, 32'h0, 1'b0);
        end
        // R4 R8: walking-one and walking-zero writes over varied lanes.
        for (int b = 0; b < 32; b++) begin
            xact(0, 1'b1, b * 7 + 3, 32'h1 << b, 1'b0);
            xact(0, 1'b1, b * 5 + 1, ~(32'h1 << b), 1'b0);
            xact(1, 1'b1, b * 7 + 2, 32'h1 << b, 1'b0);
            xact(1, 1'b1, b * 3 + 1, ~(32'h1 << b), 1'b0);
        end
        // R7: requests raised while busy.
        for (int a = 0; a < 8; a++) begin
            xact(0, 1'b0, a * 13, 32'h0, 1'b1);
            xact(0, 1'b1, a * 11, 32'hC0FFEE00 + 32'(a), 1'b1);
            xact(1, 1'b0, a * 9, 32'h0, 1'b1);
            xact(1, 1'b1, a * 17, 32'h0BADF00D ^ 32'(a), 1'b1);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule